// File: doc/BRIEF.md
# Tuner Synthesiser Serial Control Slave

This block is the two-wire (I2C) slave front end of a television tuner frequency synthesiser. It samples the open-drain SCL and SDA lines on the system clock and recognises start and stop conditions. It compares each address byte against a fixed base pattern and two selectable sub-address bits, and pulls SDA low in the acknowledge slots. Written data bytes are steered into the tuner registers by their leading bit. A byte that begins with 0 opens a divider pair, made of the upper ratio bits followed by the lower eight bits. A byte that begins with 1 opens a control pair, made of the charge-pump and test bits followed by the output-port byte.

In read mode the slave shifts out a status byte. This byte carries a power-on flag, the lock indicator, three digital port levels and a 3-bit converter code. The analog sensing of the address-select pin and of the converter pin lies outside this block: both arrive already digitised. The latched 15-bit divide ratio, the control bits and the port states drive the rest of the synthesiser directly.

Top module: `tuner_i2c_slave`

## Requirements
- R1: After reset the ratio output is 0, the control bits and port outputs are 0, SDA is not pulled, and the power-on flag is set.
- R2: An address byte is, MSB first, 1,1,0,0,0,S1,S0,RW. The slave acknowledges it when {S1,S0} is 01, or when {S1,S0} equals `addr_sel_i`. In every other case it does not acknowledge, and the data bytes that follow change nothing.
- R3: A data byte with bit 7 = 0 carries ratio bits 14..8 in its bits 6..0. The next byte carries ratio bits 7..0. `ratio_o` changes only when this second byte completes.
- R4: If a divider pair is broken after its first byte by a stop or a repeated start, `ratio_o` keeps its previous value.
- R5: A data byte with bit 7 = 1 sets CP from bit 6, T1 from bit 5, T0 from bit 4 and OS from bit 0. The next byte sets `port_o` = {P7,P6,P5,P4,P3,P0}, taken from its bits 7,6,5,4,3 and 0.
- R6: Once a pair is complete, the next data byte is classified again by its bit 7. Any number of pairs may follow a single address.
- R7: A stop that arrives in the middle of a data byte leaves every register as it was.
- R8: The slave pulls SDA low in the acknowledge slot after every data byte written to a matched address.
- R9: A read returns, MSB first, {POR, lock_i, port_in_i[2:0], adc_code_i[2:0]}, sampled when the byte starts.
- R10: When the master acknowledges a status byte, another status byte follows. When the master does not acknowledge, SDA stays released until the next start.
- R11: The power-on flag clears once a status byte carrying it has been shifted out completely, so the next status byte shows POR = 0.
- R12: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A repeated start begins a new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| addr_sel_i | input | 2 | Digitised extra sub-address select (00, 10 or 11) |
| lock_i | input | 1 | Phase-lock indicator for the status byte |
| port_in_i | input | 3 | Port levels {P7,P5,P4} for the status byte |
| adc_code_i | input | 3 | 3-bit converter code for the status byte |
| ratio_o | output | 15 | Active divide ratio |
| cp_o | output | 1 | Charge-pump current select |
| t1_o | output | 1 | Test mode bit |
| t0_o | output | 1 | Charge-pump disable bit |
| os_o | output | 1 | Varactor drive disable |
| port_o | output | 6 | Output port states {P7,P6,P5,P4,P3,P0} |

## Verification
The bench builds the block with its default parameters: a two-stage line synchroniser, the 11000 address base, the always-answered sub-address 01 and a 15-bit ratio. With these values, every combination of the four sub-addresses and the three select settings can be reached, along with the full ratio width, including the upper bits that sit in the first divider byte. Because the bus quarter-period is several times longer than the synchroniser delay, the acknowledge and read-data timing lie within reach, and so do aborts made partway through a byte.

// File: rtl/tsyn_pkg.sv
package tsyn_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } bus_state_t;

  typedef enum logic [1:0] {
    PEND_NONE,
    PEND_DIV_LO,
    PEND_PORT
  } pend_t;

  typedef struct packed {
    logic cp;
    logic t1;
    logic t0;
    logic os;
  } ctrl_t;

  // address byte check: base pattern, then sub-address against fixed or selected
  function automatic logic addr_hit(input logic [7:0] b, input logic [4:0] base,
                                    input logic [1:0] fixed_sub, input logic [1:0] sel);
    logic [1:0] sub;
    sub = b[2:1];
    return (b[7:3] == base) && ((sub == fixed_sub) || (sub == sel));
  endfunction

  function automatic logic [7:0] pack_status(input logic por, input logic fl,
                                             input logic [2:0] pins, input logic [2:0] adc);
    return {por, fl, pins, adc};
  endfunction

  function automatic ctrl_t ctrl_from_byte(input logic [7:0] b);
    ctrl_t c;
    c.cp = b[6];
    c.t1 = b[5];
    c.t0 = b[4];
    c.os = b[0];
    return c;
  endfunction

  function automatic logic [5:0] port_from_byte(input logic [7:0] b);
    return {b[7:3], b[0]};
  endfunction

endpackage

// File: rtl/tsyn_line_sync.sv
module tsyn_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] scl_c;
  logic [LAST:0] sda_c;
  logic          scl_s;
  logic          scl_d;
  logic          sda_d;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_c <= '1;
      sda_c <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_c <= {scl_c[LAST-1:0], scl_i};
      sda_c <= {sda_c[LAST-1:0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s     = scl_c[LAST];
  assign sda_s     = sda_c[LAST];
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;

  AST_LINE_EVENTS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_evt, stop_evt, scl_rise, scl_fall})); // R12

endmodule

// File: rtl/tsyn_bus_fsm.sv
module tsyn_bus_fsm
  import tsyn_pkg::*;
#(
  parameter logic [4:0] ADDR_BASE = 5'b11000,
  parameter logic [1:0] FIXED_SUB = 2'b01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic [1:0] addr_sel,
  input  logic [7:0] status_byte,
  output logic       sda_pull,
  output logic       addr_match_evt,
  output logic       wr_byte_valid,
  output logic [7:0] wr_byte,
  output logic       rd_byte_done
);
  localparam int BITS = 8;
  localparam int CW   = $clog2(BITS + 1);

  bus_state_t    state;
  logic [CW-1:0] bitcnt;
  logic [7:0]    sh;
  logic          rw;
  logic          mack;
  logic          byte_full;
  logic          hit;

  assign byte_full      = (bitcnt == CW'(BITS));
  assign hit            = addr_hit(sh, ADDR_BASE, FIXED_SUB, addr_sel);
  assign addr_match_evt = (state == ST_ADDR) && scl_fall && byte_full && hit;
  assign wr_byte_valid  = (state == ST_WDATA) && scl_fall && byte_full;
  assign wr_byte        = sh;
  assign rd_byte_done   = (state == ST_RDATA) && scl_fall && (bitcnt == CW'(BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      sh       <= '0;
      rw       <= 1'b0;
      mack     <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start_evt) begin
      state    <= ST_ADDR;
      bitcnt   <= '0;
      sda_pull <= 1'b0;
    end else if (stop_evt) begin
      state    <= ST_IDLE;
      sda_pull <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR, ST_WDATA: begin
          if (scl_rise && !byte_full) begin
            sh     <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && byte_full) begin
            if (state == ST_WDATA) begin
              state    <= ST_WACK;
              sda_pull <= 1'b1;
            end else if (hit) begin
              state    <= ST_AACK;
              rw       <= sh[0];
              sda_pull <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rw) begin
              state    <= ST_RDATA;
              sh       <= status_byte;
              sda_pull <= ~status_byte[7];
            end else begin
              state    <= ST_WDATA;
              sda_pull <= 1'b0;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            state    <= ST_WDATA;
            bitcnt   <= '0;
            sda_pull <= 1'b0;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bitcnt == CW'(BITS - 1)) begin
              state    <= ST_RACK;
              sda_pull <= 1'b0;
            end else begin
              sh       <= {sh[6:0], 1'b0};
              sda_pull <= ~sh[6];
              bitcnt   <= bitcnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            bitcnt <= '0;
            if (mack) begin
              state    <= ST_RDATA;
              sh       <= status_byte;
              sda_pull <= ~status_byte[7];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ADDR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match_evt |=> sda_pull); // R2
  AST_WRITE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte_valid && !start_evt && !stop_evt |=> sda_pull); // R8
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull); // R10
  AST_RACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_byte_done |=> !sda_pull); // R10

endmodule

// File: rtl/tsyn_regs.sv
module tsyn_regs
  import tsyn_pkg::*;
#(
  parameter int RATIO_W = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               addr_match_evt,
  input  logic               wr_byte_valid,
  input  logic [7:0]         wr_byte,
  input  logic               rd_byte_done,
  input  logic               lock_i,
  input  logic [2:0]         port_in_i,
  input  logic [2:0]         adc_code_i,
  output logic [RATIO_W-1:0] ratio,
  output ctrl_t              ctrl,
  output logic [5:0]         port,
  output logic [7:0]         status_byte
);
  localparam int HI_W = RATIO_W - 8;

  pend_t           pend;
  logic [HI_W-1:0] div_hi;
  logic            por_q;
  logic            div_commit;

  assign div_commit  = wr_byte_valid && (pend == PEND_DIV_LO);
  assign status_byte = pack_status(por_q, lock_i, port_in_i, adc_code_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= PEND_NONE;
      div_hi <= '0;
      ratio  <= '0;
      ctrl   <= '0;
      port   <= '0;
      por_q  <= 1'b1;
    end else begin
      if (rd_byte_done) por_q <= 1'b0;
      if (addr_match_evt) begin
        pend <= PEND_NONE;
      end else if (wr_byte_valid) begin
        unique case (pend)
          PEND_DIV_LO: begin
            ratio <= {div_hi, wr_byte};
            pend  <= PEND_NONE;
          end
          PEND_PORT: begin
            port <= port_from_byte(wr_byte);
            pend <= PEND_NONE;
          end
          default: begin
            if (!wr_byte[7]) begin
              div_hi <= wr_byte[HI_W-1:0];
              pend   <= PEND_DIV_LO;
            end else begin
              ctrl <= ctrl_from_byte(wr_byte);
              pend <= PEND_PORT;
            end
          end
        endcase
      end
    end
  end

  AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !div_commit |=> $stable(ratio)); // R3
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_byte_valid |=> $stable(ctrl) && $stable(port)); // R5
  AST_POR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_q) |-> $past(rd_byte_done)); // R11

endmodule

// File: rtl/tuner_i2c_slave.sv
module tuner_i2c_slave
  import tsyn_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         RATIO_W     = 15,
  parameter logic [4:0] ADDR_BASE   = 5'b11000,
  parameter logic [1:0] FIXED_SUB   = 2'b01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic [1:0]         addr_sel_i,
  input  logic               lock_i,
  input  logic [2:0]         port_in_i,
  input  logic [2:0]         adc_code_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               cp_o,
  output logic               t1_o,
  output logic               t0_o,
  output logic               os_o,
  output logic [5:0]         port_o
);
  logic       sda_s;
  logic       start_evt;
  logic       stop_evt;
  logic       scl_rise;
  logic       scl_fall;
  logic       addr_match_evt;
  logic       wr_byte_valid;
  logic [7:0] wr_byte;
  logic       rd_byte_done;
  logic [7:0] status_byte;
  ctrl_t      ctrl;

  tsyn_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall)
  );

  tsyn_bus_fsm #(.ADDR_BASE(ADDR_BASE), .FIXED_SUB(FIXED_SUB)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .sda_s          (sda_s),
    .start_evt      (start_evt),
    .stop_evt       (stop_evt),
    .scl_rise       (scl_rise),
    .scl_fall       (scl_fall),
    .addr_sel       (addr_sel_i),
    .status_byte    (status_byte),
    .sda_pull       (sda_pull_o),
    .addr_match_evt (addr_match_evt),
    .wr_byte_valid  (wr_byte_valid),
    .wr_byte        (wr_byte),
    .rd_byte_done   (rd_byte_done)
  );

  tsyn_regs #(.RATIO_W(RATIO_W)) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .addr_match_evt (addr_match_evt),
    .wr_byte_valid  (wr_byte_valid),
    .wr_byte        (wr_byte),
    .rd_byte_done   (rd_byte_done),
    .lock_i         (lock_i),
    .port_in_i      (port_in_i),
    .adc_code_i     (adc_code_i),
    .ratio          (ratio_o),
    .ctrl           (ctrl),
    .port           (port_o),
    .status_byte    (status_byte)
  );

  assign cp_o = ctrl.cp;
  assign t1_o = ctrl.t1;
  assign t0_o = ctrl.t0;
  assign os_o = ctrl.os;

  AST_STOP_KEEPS_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> $stable(ratio_o)); // R7

endmodule

// File: tb/test_tuner_i2c_slave.sv
module test_tuner_i2c_slave;
  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [1:0]  sel = 2'b00;
  logic        lock = 1'b0;
  logic [2:0]  pins = 3'b000;
  logic [2:0]  adc = 3'b000;
  wire         sda_pull;
  wire         sda_line;
  wire  [14:0] ratio;
  wire         cp, t1, t0, os;
  wire  [5:0]  port;

  assign sda_line = sda_m & ~sda_pull;

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  logic [14:0] e_ratio = '0;
  logic [3:0]  e_ctrl  = '0;
  logic [5:0]  e_port  = '0;

  tuner_i2c_slave i_tuner_i2c_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull),
    .addr_sel_i (sel),
    .lock_i     (lock),
    .port_in_i  (pins),
    .adc_code_i (adc),
    .ratio_o    (ratio),
    .cp_o       (cp),
    .t1_o       (t1),
    .t0_o       (t0),
    .os_o       (os),
    .port_o     (port)
  );

  function automatic logic [7:0] f_addr(input logic [1:0] sub, input logic rd);
    return {5'b11000, sub, rd};
  endfunction

  function automatic logic f_hit(input logic [1:0] sub, input logic [1:0] s);
    return (sub == 2'b01) || (sub == s);
  endfunction

  function automatic logic [7:0] f_status(input logic p, input logic l,
                                          input logic [2:0] i, input logic [2:0] a);
    logic [7:0] v;
    v[7] = p; v[6] = l; v[5:3] = i; v[2:0] = a;
    return v;
  endfunction

  function automatic logic [7:0] f_ctrl_byte(input logic [3:0] c);
    return {1'b1, c[3], c[2], c[1], 3'b111, c[0]};
  endfunction

  function automatic logic [5:0] f_port_of(input logic [7:0] b);
    return {b[7], b[6], b[5], b[4], b[3], b[0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    ack = ~sda_line;
    wq(); scl_m = 1'b0; wq();
  endtask

  task automatic read_byte(input logic m_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0;
    end
    wq(); sda_m = ~m_ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq(); sda_m = 1'b1;
  endtask

  task automatic chk_outputs(input string req);
    chk(req, {17'd0, ratio}, {17'd0, e_ratio});
    chk(req, {28'd0, cp, t1, t0, os}, {28'd0, e_ctrl});
    chk(req, {26'd0, port}, {26'd0, e_port});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic       a;
    logic [7:0] rb;
    logic [14:0] r;
    logic [3:0] c;
    logic [7:0] pb;
    void'($urandom(32'd4242));

    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk_outputs("R1");
    chk("R1 sda", {31'd0, sda_pull}, 32'd0);

    // R9 R11 R10: read after reset, POR set then cleared
    lock = 1'b1; pins = 3'b101; adc = 3'b010;
    bus_start();
    send_byte(f_addr(2'b01, 1'b1), a);
    chk("R2 read addr ack", {31'd0, a}, 32'd1);
    read_byte(1'b1, rb);
    chk("R9 R1 status por", {24'd0, rb}, {24'd0, f_status(1'b1, 1'b1, 3'b101, 3'b010)});
    read_byte(1'b0, rb);
    chk("R11 R10 second status", {24'd0, rb}, {24'd0, f_status(1'b0, 1'b1, 3'b101, 3'b010)});
    chk("R10 released after nack", {31'd0, sda_pull}, 32'd0);
    bus_stop();

    // R3 R8 divider pair
    bus_start();
    send_byte(f_addr(2'b00, 1'b0), a);
    chk("R2 sel00", {31'd0, a}, 32'd1);
    send_byte({1'b0, 7'h55}, a);
    chk("R8 hi ack", {31'd0, a}, 32'd1);
    chk("R3 hold after hi", {17'd0, ratio}, 32'd0);
    send_byte(8'hA3, a);
    chk("R8 lo ack", {31'd0, a}, 32'd1);
    e_ratio = {7'h55, 8'hA3};
    chk_outputs("R3");
    bus_stop();

    // R4 broken pair
    bus_start();
    send_byte(f_addr(2'b01, 1'b0), a);
    send_byte({1'b0, 7'h12}, a);
    bus_stop();
    chk_outputs("R4 stop");

    // R5 control and port
    bus_start();
    send_byte(f_addr(2'b01, 1'b0), a);
    send_byte(f_ctrl_byte(4'b1011), a);
    send_byte(8'b1010_1101, a);
    chk("R8 port ack", {31'd0, a}, 32'd1);
    bus_stop();
    e_ctrl = 4'b1011; e_port = f_port_of(8'b1010_1101);
    chk_outputs("R5");

    // R6 sweep without re-addressing
    bus_start();
    send_byte(f_addr(2'b01, 1'b0), a);
    send_byte(8'h01, a); send_byte(8'h02, a);
    chk("R6 first pair", {17'd0, ratio}, 32'h0102);
    send_byte(8'h01, a); send_byte(8'h03, a);
    send_byte(f_ctrl_byte(4'b0100), a); send_byte(8'b0101_0010, a);
    bus_stop();
    e_ratio = 15'h0103; e_ctrl = 4'b0100; e_port = f_port_of(8'b0101_0010);
    chk_outputs("R6");

    // R7 stop mid-byte (hi byte partial, and lo byte partial)
    bus_start();
    send_byte(f_addr(2'b01, 1'b0), a);
    send_bits(8'h7F, 4);
    bus_stop();
    chk_outputs("R7 partial hi");
    bus_start();
    send_byte(f_addr(2'b01, 1'b0), a);
    send_byte(8'h7F, a);
    send_bits(8'hFF, 5);
    bus_stop();
    chk_outputs("R7 partial lo");
    bus_start();
    send_byte(f_addr(2'b01, 1'b0), a);
    send_byte(f_ctrl_byte(4'b1111), a);
    chk("R5 ctrl after one byte", {28'd0, cp, t1, t0, os}, 32'hF);
    e_ctrl = 4'b1111;
    send_bits(8'hFF, 3);
    bus_stop();
    chk_outputs("R7 partial port");

    // R2 negatives and select
    sel = 2'b10;
    bus_start();
    send_byte(f_addr(2'b00, 1'b0), a);
    chk("R2 sub00 sel10 nack", {31'd0, a}, 32'd0);
    send_byte(8'h3F, a); send_byte(8'hFF, a);
    chk("R2 data ignored nack", {31'd0, a}, 32'd0);
    bus_stop();
    chk_outputs("R2 ignored");
    bus_start();
    send_byte(8'hA2, a);
    chk("R2 wrong base", {31'd0, a}, 32'd0);
    bus_stop();
    bus_start();
    send_byte(f_addr(2'b10, 1'b0), a);
    chk("R2 sub10 sel10", {31'd0, a}, 32'd1);
    bus_stop();
    bus_start();
    send_byte(f_addr(2'b11, 1'b0), a);
    chk("R2 sub11 sel10 nack", {31'd0, a}, 32'd0);
    bus_stop();

    // R12 R4: repeated start abandons divider pair
    bus_start();
    send_byte(f_addr(2'b01, 1'b0), a);
    send_byte(8'h44, a);
    bus_start();
    send_byte(f_addr(2'b01, 1'b0), a);
    chk("R12 re-address ack", {31'd0, a}, 32'd1);
    send_byte(f_ctrl_byte(4'b0001), a);
    send_byte(8'b0000_1000, a);
    bus_stop();
    e_ctrl = 4'b0001; e_port = f_port_of(8'b0000_1000);
    chk_outputs("R12 R4 restart");

    // random traffic
    for (int k = 0; k < 30; k++) begin
      logic [1:0] rsub;
      logic hit;
      int units;
      case ($urandom % 3)
        0: sel = 2'b00;
        1: sel = 2'b10;
        default: sel = 2'b11;
      endcase
      rsub = 2'($urandom % 4);
      hit = f_hit(rsub, sel);
      if ($urandom % 4 == 0) begin
        lock = 1'($urandom); pins = 3'($urandom); adc = 3'($urandom);
        bus_start();
        send_byte(f_addr(rsub, 1'b1), a);
        chk("R2 rand read addr", {31'd0, a}, {31'd0, hit});
        if (hit) begin
          read_byte(1'b0, rb);
          chk("R9 rand status", {24'd0, rb}, {24'd0, f_status(1'b0, lock, pins, adc)});
        end
        bus_stop();
      end else begin
        bus_start();
        send_byte(f_addr(rsub, 1'b0), a);
        chk("R2 rand addr", {31'd0, a}, {31'd0, hit});
        units = 1 + ($urandom % 3);
        for (int u = 0; u < units; u++) begin
          if ($urandom % 2 == 1) begin
            r = 15'($urandom);
            send_byte({1'b0, r[14:8]}, a);
            chk("R8 rand hi", {31'd0, a}, {31'd0, hit});
            send_byte(r[7:0], a);
            if (hit) e_ratio = r;
          end else begin
            c = 4'($urandom); pb = 8'($urandom);
            send_byte(f_ctrl_byte(c), a);
            send_byte(pb, a);
            chk("R8 rand port", {31'd0, a}, {31'd0, hit});
            if (hit) begin
              e_ctrl = c; e_port = f_port_of(pb);
            end
          end
        end
        bus_stop();
        chk_outputs("R6 rand");
      end
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule